// File: doc/BRIEF.md
# Flag-Generating Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It takes two operands, an incoming carry and an operation code. It returns the result, a zero flag, a carry out of the low half of the word (digit carry) and a carry out of the top bit. Alongside those three flag values it drives three write enables. The enables tell a status register held elsewhere which flags the current operation is allowed to change.

Subtraction adds the two's complement of the second operand to the first. Carry and digit carry therefore read as inverted borrows: 1 means nothing was borrowed. Both rotate directions pass through the carry: the incoming carry fills the vacated bit, and the bit shifted out becomes the new carry. The word width is a parameter, and the digit-carry point sits at half the width. A second parameter chooses between a two-segment behavioural adder and an explicit ripple chain.

Top module: `flag_alu`

## Requirements
- R1: Op code 0 (add) gives result = (A + B) mod 2^W. The carry flag is the carry out of bit W-1 and the digit carry is the carry out of bit W/2-1. All three enables are 1.
- R2: Op code 1 (subtract) gives result = (A - B) mod 2^W, formed as A + ~B + 1. The carry flag is 1 exactly when A >= B (unsigned). The digit carry is 1 exactly when the low half of A is >= the low half of B. All three enables are 1.
- R3: For every op code, zero_flag is 1 exactly when the result is all zeros.
- R4: Op codes 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and NOT A. Only zero_we is 1.
- R5: Op codes 6 and 7 give A + 1 and A - 1, wrapping modulo 2^W. Only zero_we is 1.
- R6: Op code 9 (rotate left) gives {A[W-2:0], carry_in} with carry flag A[W-1]. Op code 10 (rotate right) gives {carry_in, A[W-1:1]} with carry flag A[0]. Only carry_we is 1.
- R7: Op code 8 exchanges the upper and lower halves of A. All enables are 0.
- R8: Op codes 11 to 15 pass A through unchanged. All enables are 0.
- R9: digit_carry_flag is 0 whenever digit_carry_we is 0, and carry_flag is 0 whenever carry_we is 0.
- R10: carry_in has no effect on any output except under op codes 9 and 10.
- R11: The behavioural adder variant and the ripple adder variant give identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | WIDTH | First operand; the source for unary ops |
| opd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Current carry, used by the rotates |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| digit_carry_flag | output | 1 | Carry out of the low half |
| carry_flag | output | 1 | Carry out of the top bit, or the rotated-out bit |
| zero_we | output | 1 | Zero flag may be written |
| digit_carry_we | output | 1 | Digit carry flag may be written |
| carry_we | output | 1 | Carry flag may be written |

## Verification
The bench builds two 8-bit instances with the same inputs, one with the behavioural adder and one with the ripple chain. This lets every stimulus compare the two adder variants against each other and against an arithmetic model. With an 8-bit word, every value of the first operand can be swept against varied second operands under all sixteen op codes. The same width makes the boundary cases easy to reach: wrap at 0xFF, nibble carries at 0x0F, equal operands in subtraction, and borrows in only one half.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_NOT  = 4'd5,
      OP_INC  = 4'd6,
      OP_DEC  = 4'd7,
      OP_SWAP = 4'd8,
      OP_ROL  = 4'd9,
      OP_ROR  = 4'd10
   } alu_op_e;

   typedef struct packed {
      logic z;
      logic dc;
      logic c;
   } flag_set_t;

   // Which flags an operation is allowed to write
   function automatic flag_set_t op_updates(input logic [3:0] op);
      flag_set_t m;
      case (op)
         OP_ADD, OP_SUB:                          m = '{z: 1'b1, dc: 1'b1, c: 1'b1};
         OP_AND, OP_OR, OP_XOR, OP_NOT,
         OP_INC, OP_DEC:                          m = '{z: 1'b1, dc: 1'b0, c: 1'b0};
         OP_ROL, OP_ROR:                          m = '{z: 1'b0, dc: 1'b0, c: 1'b1};
         default:                                 m = '{z: 1'b0, dc: 1'b0, c: 1'b0};
      endcase
      return m;
   endfunction

   function automatic logic uses_adder(input logic [3:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
   endfunction

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
   parameter int WIDTH    = 8,
   parameter int HALF     = WIDTH / 2,
   parameter bit FAST_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             half_carry,
   output logic             carry_out
);
   localparam int UPPER = WIDTH - HALF;

   generate
      if (FAST_ADD) begin : g_segmented
         logic [HALF:0]  lo_seg;
         logic [UPPER:0] hi_seg;
         assign lo_seg = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
         assign hi_seg = {1'b0, a[WIDTH-1:HALF]} + {1'b0, b[WIDTH-1:HALF]}
                       + {{UPPER{1'b0}}, lo_seg[HALF]};
         assign sum        = {hi_seg[UPPER-1:0], lo_seg[HALF-1:0]};
         assign half_carry = lo_seg[HALF];
         assign carry_out  = hi_seg[UPPER];
      end else begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]      = a[i] ^ b[i] ^ chain[i];
            assign chain[i+1]  = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
         end
         assign half_carry = chain[HALF];
         assign carry_out  = chain[WIDTH];
      end
   endgenerate

   always_comb begin
      assert_adder_total_R11: assert ({carry_out, sum} ==
            ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
         else $error("adder total mismatch");
   end

endmodule

// File: rtl/flag_alu_bitops.sv
module flag_alu_bitops #(
   parameter int WIDTH = 8,
   parameter int HALF  = WIDTH / 2
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic [3:0]       op,
   output logic [WIDTH-1:0] bit_res,
   output logic             shifted_out
);
   import flag_alu_pkg::*;

   always_comb begin
      shifted_out = 1'b0;
      case (op)
         OP_AND:  bit_res = a & b;
         OP_OR:   bit_res = a | b;
         OP_XOR:  bit_res = a ^ b;
         OP_NOT:  bit_res = ~a;
         OP_SWAP: bit_res = {a[HALF-1:0], a[WIDTH-1:HALF]};
         OP_ROL: begin
            bit_res     = {a[WIDTH-2:0], cin};
            shifted_out = a[WIDTH-1];
         end
         OP_ROR: begin
            bit_res     = {cin, a[WIDTH-1:1]};
            shifted_out = a[0];
         end
         default: bit_res = a;
      endcase
   end

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags #(
   parameter int WIDTH = 8
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] res,
   input  logic             add_dc,
   input  logic             add_c,
   input  logic             rot_c,
   output logic             z,
   output logic             dc,
   output logic             c,
   output logic             z_we,
   output logic             dc_we,
   output logic             c_we
);
   import flag_alu_pkg::*;

   flag_set_t upd;

   always_comb begin
      upd   = op_updates(op);
      z_we  = upd.z;
      dc_we = upd.dc;
      c_we  = upd.c;
      z     = (res == '0);
      dc    = upd.dc & add_dc;
      c     = upd.c & (((op == OP_ROL) || (op == OP_ROR)) ? rot_c : add_c);
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
   parameter int WIDTH    = 8,
   parameter bit FAST_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] opd_a,
   input  logic [WIDTH-1:0] opd_b,
   input  logic             carry_in,
   input  logic [3:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag,
   output logic             digit_carry_flag,
   output logic             carry_flag,
   output logic             zero_we,
   output logic             digit_carry_we,
   output logic             carry_we
);
   import flag_alu_pkg::*;

   localparam int HALF = WIDTH / 2;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("flag_alu: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] add_b, add_sum, bit_res;
   logic             add_cin, add_dc, add_c, rot_c;

   // Operand shaping: subtract and decrement reuse the adder
   always_comb begin
      add_b   = opd_b;
      add_cin = 1'b0;
      case (op_sel)
         OP_SUB: begin add_b = ~opd_b;      add_cin = 1'b1; end
         OP_INC: begin add_b = '0;          add_cin = 1'b1; end
         OP_DEC: begin add_b = '1;          add_cin = 1'b0; end
         default: ;
      endcase
   end

   flag_alu_adder #(.WIDTH(WIDTH), .HALF(HALF), .FAST_ADD(FAST_ADD)) u_adder (
      .a(opd_a), .b(add_b), .cin(add_cin),
      .sum(add_sum), .half_carry(add_dc), .carry_out(add_c)
   );

   flag_alu_bitops #(.WIDTH(WIDTH), .HALF(HALF)) u_bitops (
      .a(opd_a), .b(opd_b), .cin(carry_in), .op(op_sel),
      .bit_res(bit_res), .shifted_out(rot_c)
   );

   assign result = uses_adder(op_sel) ? add_sum : bit_res;

   flag_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .op(op_sel), .res(result), .add_dc(add_dc), .add_c(add_c), .rot_c(rot_c),
      .z(zero_flag), .dc(digit_carry_flag), .c(carry_flag),
      .z_we(zero_we), .dc_we(digit_carry_we), .c_we(carry_we)
   );

   always_comb begin
      if (op_sel == OP_ADD)
         assert_add_total_R1: assert ({carry_flag, result} == ({1'b0, opd_a} + {1'b0, opd_b}))
            else $error("add result/carry mismatch");
      if (op_sel == OP_SUB)
         assert_sub_borrow_R2: assert (carry_flag == (opd_a >= opd_b))
            else $error("subtract inverted borrow mismatch");
      assert_zero_R3: assert (zero_flag == (result == '0))
         else $error("zero flag mismatch");
      if (op_sel == OP_ROL)
         assert_rol_carry_R6: assert (carry_flag == opd_a[WIDTH-1] && result[0] == carry_in)
            else $error("rotate-left carry mismatch");
      if (op_sel == OP_ROR)
         assert_ror_carry_R6: assert (carry_flag == opd_a[0] && result[WIDTH-1] == carry_in)
            else $error("rotate-right carry mismatch");
      if (op_sel >= 4'd8 && op_sel != OP_ROL && op_sel != OP_ROR)
         assert_no_update_R7: assert (!zero_we && !digit_carry_we && !carry_we)
            else $error("swap or reserved op enabled a flag");
      assert_gated_R9: assert ((digit_carry_we || !digit_carry_flag) && (carry_we || !carry_flag))
         else $error("flag value set while its enable is low");
   end

endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] a, b;
   logic         cin;
   logic [3:0]   op;

   logic [W-1:0] res_f, res_r;
   logic z_f, dc_f, c_f, zwe_f, dcwe_f, cwe_f;
   logic z_r, dc_r, c_r, zwe_r, dcwe_r, cwe_r;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   flag_alu #(.WIDTH(W), .FAST_ADD(1'b1)) u_flag_alu (
      .opd_a(a), .opd_b(b), .carry_in(cin), .op_sel(op),
      .result(res_f), .zero_flag(z_f), .digit_carry_flag(dc_f), .carry_flag(c_f),
      .zero_we(zwe_f), .digit_carry_we(dcwe_f), .carry_we(cwe_f));

   flag_alu #(.WIDTH(W), .FAST_ADD(1'b0)) u_flag_alu_ripple (
      .opd_a(a), .opd_b(b), .carry_in(cin), .op_sel(op),
      .result(res_r), .zero_flag(z_r), .digit_carry_flag(dc_r), .carry_flag(c_r),
      .zero_we(zwe_r), .digit_carry_we(dcwe_r), .carry_we(cwe_r));

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (op=%0d a=%0h b=%0h cin=%0b)",
                  tag, what, act, exp, op, a, b, cin);
      end
   endtask

   // Apply one stimulus and compare both instances against the model
   task automatic run(input int o, input int av, input int bv, input bit ci, input string tag);
      int er, ec, edc, ez, ezw, edw, ecw;
      @(posedge clk);
      op = o[3:0]; a = av[W-1:0]; b = bv[W-1:0]; cin = ci;
      av = av & 255; bv = bv & 255;
      ec = 0; edc = 0; ezw = 0; edw = 0; ecw = 0;
      case (o)
         0: begin er = (av + bv) & 255; ec = (av + bv) >> 8;
                  edc = ((av & 15) + (bv & 15)) >> 4; ezw = 1; edw = 1; ecw = 1; end
         1: begin er = (av - bv) & 255; ec = (av >= bv); edc = ((av & 15) >= (bv & 15));
                  ezw = 1; edw = 1; ecw = 1; end
         2: begin er = av & bv; ezw = 1; end
         3: begin er = av | bv; ezw = 1; end
         4: begin er = av ^ bv; ezw = 1; end
         5: begin er = (~av) & 255; ezw = 1; end
         6: begin er = (av + 1) & 255; ezw = 1; end
         7: begin er = (av + 255) & 255; ezw = 1; end
         8: er = ((av & 15) << 4) | (av >> 4);
         9: begin er = ((av << 1) | ci) & 255; ec = av >> 7; ecw = 1; end
         10: begin er = (ci << 7) | (av >> 1); ec = av & 1; ecw = 1; end
         default: er = av;
      endcase
      ez = (er == 0);
      @(negedge clk);
      check(tag, "result", res_f, er);
      check(tag, "zero_flag", z_f, ez);
      check(tag, "dc_flag", dc_f, edc);
      check(tag, "c_flag", c_f, ec);
      check(tag, "zero_we", zwe_f, ezw);
      check(tag, "dc_we", dcwe_f, edw);
      check(tag, "c_we", cwe_f, ecw);
      check("R11", "ripple result", res_r, res_f);
      check("R11", "ripple flags", {z_r, dc_r, c_r, zwe_r, dcwe_r, cwe_r},
                                   {z_f, dc_f, c_f, zwe_f, dcwe_f, cwe_f});
   endtask

   task automatic t_reset_state();
      run(0, 0, 0, 0, "R3 reset idle");
   endtask

   task automatic t_add();
      run(0, 8'h12, 8'h34, 0, "R1 plain");
      run(0, 8'h0F, 8'h01, 0, "R1 digit carry");
      run(0, 8'hF0, 8'h10, 0, "R1 carry and zero");
      run(0, 8'hFF, 8'h01, 1, "R1 full wrap");
      run(0, 8'h88, 8'h88, 0, "R1 both carries");
   endtask

   task automatic t_sub();
      run(1, 5, 3, 0, "R2 no borrow");
      run(1, 3, 5, 0, "R2 borrow");
      run(1, 8'h10, 8'h01, 0, "R2 low-half borrow only");
      run(1, 8'h5A, 8'h5A, 1, "R2 equal gives zero");
      run(1, 0, 8'hFF, 0, "R2 max borrow");
   endtask

   task automatic t_logic();
      run(2, 8'hF0, 8'h0F, 0, "R4 and zero");
      run(3, 8'hA0, 8'h05, 1, "R4 or");
      run(4, 8'h3C, 8'h3C, 0, "R4 xor zero");
      run(5, 8'hFF, 8'h00, 0, "R4 not zero");
   endtask

   task automatic t_incdec();
      run(6, 8'hFF, 8'h77, 1, "R5 inc wrap");
      run(6, 8'h0F, 0, 0, "R5 inc no dc");
      run(7, 8'h00, 8'h77, 0, "R5 dec wrap");
      run(7, 8'h01, 0, 1, "R5 dec to zero");
   endtask

   task automatic t_rotate();
      run(9, 8'h80, 0, 0, "R6 rol out high");
      run(9, 8'h00, 0, 1, "R6 rol carry in");
      run(10, 8'h01, 0, 0, "R6 ror out low zero");
      run(10, 8'h00, 0, 1, "R6 ror carry in");
   endtask

   task automatic t_swap_reserved();
      run(8, 8'hA5, 8'h11, 1, "R7 swap");
      run(8, 8'h00, 0, 0, "R7 swap zero");
      for (int o = 11; o < 16; o++) run(o, 8'hC3, 8'h3C, 1, "R8 reserved");
   endtask

   task automatic t_gating_and_cin();
      for (int o = 0; o < 16; o++) begin
         run(o, 8'hFF, 8'hFF, 0, "R9 R10 cin low");
         run(o, 8'hFF, 8'hFF, 1, "R9 R10 cin high");
      end
   endtask

   task automatic t_sweep();
      for (int o = 0; o < 16; o++)
         for (int v = 0; v < 256; v++)
            run(o, v, (v * 37 + o * 11) & 255, v[0] ^ o[0], "R1 R2 R3 R11 sweep");
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0; op = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_add();
      t_sub();
      t_logic();
      t_incdec();
      t_rotate();
      t_swap_reserved();
      t_gating_and_cin();
      t_sweep();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule